// File: doc/BRIEF.md
# Triggered fractional clock divider

This block derives a divided clock-enable pulse stream from one of several parent enable streams. It models the clock in cycles: each parent appears as a one-cycle request pulse, and the output is a one-cycle pulse at the divided rate. The parent choice, an integer pre-divider and a downstream divider with low-order fraction bits are all written first into staging registers. Writes to the staging registers change nothing on the output.

Settings move from staging to the active registers only through a commit. A pre-trigger commits the parent selector and the pre-divider together. A main trigger commits the downstream divider. Each trigger has a busy flag that software can poll: it reads 1 from the cycle after the trigger until the change has settled, then clears by itself.

The downstream divider stores one less than its divisor. The minus-one applies to the integer bits above the fraction, so the scaled divisor is the field value plus 2^FRAC_W. An accumulator adds 2^FRAC_W on each pre-divided tick. When the sum reaches the scaled divisor, the block emits a pulse and keeps the remainder. While `gate_en` is low, the block drops staged writes, ignores triggers and keeps its output quiet.

Top module: `trig_frac_clkdiv`

## Requirements
- R1: While reset is held and on the first cycle after it, both busy flags are 0 and `div_pulse` is 0. The active divider and pre-divider are 0, and the active selector is all ones (7), which names no parent.
- R2: With a divider field d and 3 fraction bits, the output averages 8/(d+8) pulses per pre-divided tick. For example, d=16 gives one pulse per 3 ticks and d=255 gives one pulse per 32.875 ticks.
- R3: Fraction bits give non-integer ratios. For example, d=4 gives 2 pulses per 3 ticks and d=3 gives 8 pulses per 11 ticks.
- R4: The pre-divider field p passes one tick on for every p+1 pulses of the selected parent.
- R5: The selector value s routes `parent_req[s]` when s < NPAR. For any s >= NPAR, `div_pulse` stays 0.
- R6: Staging writes use `wr_addr` 0 for the divider, 1 for the pre-divider (low 4 bits) and 2 for the selector (low 3 bits). They do not change the active values or the output until a commit. The main trigger commits only the divider, and the pre-trigger commits only the selector and the pre-divider.
- R7: A pre-trigger sampled at clock edge T sets `pre_busy` after T. When no defined parent is selected, the new selector and pre-divider are active after edge T+1, and `pre_busy` reads 0 after edge T+3.
- R8: A main commit lands on the edge that produces an output pulse, so `act_div` changes in the same cycle `div_pulse` is 1. `main_busy` stays 1 for one further cycle and reads 0 two cycles after the commit.
- R9: While `gate_en` is 0, staging writes are dropped, triggers are ignored so the busy flags stay 0, and `div_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_en | input | 1 | Clock enable: output running and writes accepted |
| parent_req | input | NPAR | One-cycle enable pulses of each parent |
| wr_en | input | 1 | Staging write strobe |
| wr_addr | input | 2 | Staging field: 0 divider, 1 pre-divider, 2 selector |
| wr_data | input | DIV_W | Staging write data |
| go_main | input | 1 | Main trigger: commit divider |
| go_pre | input | 1 | Pre-trigger: commit selector and pre-divider |
| main_busy | output | 1 | Main commit in progress |
| pre_busy | output | 1 | Pre commit in progress |
| div_pulse | output | 1 | Divided enable pulse |
| act_div | output | DIV_W | Active divider field |
| act_pre | output | PRE_W | Active pre-divider field |
| act_sel | output | SEL_W | Active selector field |

## Verification
A selected parent pulse reaches `div_pulse` one edge later. The rate checks therefore commit first, wait four idle cycles, and only then count pulses over a 240-cycle window. Because the accumulator phase at the window start is arbitrary, each count is compared with the integer rate formula within one pulse, except where the expected count is zero, which must match exactly. Busy and active-value checks are sampled one time unit after each edge: the pre-trigger sequence is stepped edge by edge (busy after T, new selector after T+1, clear after T+3), and the main commit is checked by finding the sample where `act_div` first changes and then reading `main_busy` on the next two samples.

// File: rtl/trig_frac_clkdiv.sv
module trig_frac_clkdiv #(
  parameter int NPAR    = 4,
  parameter int DIV_W   = 8,
  parameter int FRAC_W  = 3,
  parameter int PRE_W   = 4,
  parameter int SEL_W   = 3,
  parameter int SEL_RST = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic [NPAR-1:0]  parent_req,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             go_main,
  input  logic             go_pre,
  output logic             main_busy,
  output logic             pre_busy,
  output logic             div_pulse,
  output logic [DIV_W-1:0] act_div,
  output logic [PRE_W-1:0] act_pre,
  output logic [SEL_W-1:0] act_sel
);
  localparam int ACC_W = DIV_W + 2;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1 << FRAC_W);

  logic [DIV_W-1:0] stg_div;
  logic [PRE_W-1:0] stg_pre;
  logic [SEL_W-1:0] stg_sel;
  logic [PRE_W-1:0] pre_cnt;
  logic [ACC_W-1:0] acc;
  logic [1:0]       main_tail, pre_tail;
  logic             sel_in;

  wire sel_ok = {1'b0, act_sel} < (SEL_W+1)'(NPAR);

  always_comb begin
    sel_in = 1'b0;
    for (int i = 0; i < NPAR; i++)
      if (act_sel == SEL_W'(i)) sel_in = parent_req[i];
  end

  wire              pre_hit = gate_en && sel_in && (pre_cnt == act_pre);
  wire [ACC_W-1:0]  scaled  = ACC_W'(act_div) + ONE;
  wire [ACC_W-1:0]  sum     = acc + ONE;
  wire              wrap    = sum >= scaled;

  wire main_edge = main_busy && (main_tail == 2'd0) && ((pre_hit && wrap) || !sel_ok);
  wire pre_edge  = pre_busy && (pre_tail == 2'd0) && ((pre_cnt == '0) || !sel_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_div <= '0;
      stg_pre <= '0;
      stg_sel <= SEL_W'(SEL_RST);
    end else if (gate_en && wr_en) begin
      case (wr_addr)
        2'd0:    stg_div <= wr_data;
        2'd1:    stg_pre <= wr_data[PRE_W-1:0];
        2'd2:    stg_sel <= wr_data[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_div <= '0;
      act_pre <= '0;
      act_sel <= SEL_W'(SEL_RST);
    end else begin
      if (main_edge) act_div <= stg_div;
      if (pre_edge) begin
        act_pre <= stg_pre;
        act_sel <= stg_sel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      acc       <= '0;
      div_pulse <= 1'b0;
    end else begin
      if (pre_edge)
        pre_cnt <= '0;
      else if (gate_en && sel_in)
        pre_cnt <= (pre_cnt == act_pre) ? '0 : pre_cnt + 1'b1;
      if (main_edge)
        acc <= '0;
      else if (pre_hit)
        acc <= wrap ? sum - scaled : sum;
      div_pulse <= pre_hit && wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_busy <= 1'b0;
      main_tail <= '0;
    end else begin
      if (main_edge) main_tail <= 2'd2;
      else if (main_tail != 2'd0) main_tail <= main_tail - 1'b1;
      if (go_main && gate_en && !main_busy) main_busy <= 1'b1;
      else if (main_tail == 2'd1) main_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_busy <= 1'b0;
      pre_tail <= '0;
    end else begin
      if (pre_edge) pre_tail <= 2'd2;
      else if (pre_tail != 2'd0) pre_tail <= pre_tail - 1'b1;
      if (go_pre && gate_en && !pre_busy) pre_busy <= 1'b1;
      else if (pre_tail == 2'd1) pre_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_frac_clkdiv_chk.sv
module trig_frac_clkdiv_chk #(
  parameter int NPAR  = 4,
  parameter int DIV_W = 8,
  parameter int PRE_W = 4,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_en,
  input logic             go_main,
  input logic             go_pre,
  input logic             main_busy,
  input logic             pre_busy,
  input logic             div_pulse,
  input logic [DIV_W-1:0] act_div,
  input logic [PRE_W-1:0] act_pre,
  input logic [SEL_W-1:0] act_sel
);
  // R9
  gate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !div_pulse);

  // R5
  no_parent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, act_sel} >= (SEL_W+1)'(NPAR)) |=> !div_pulse);

  // R6
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_busy |=> $stable(act_div));

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_busy |=> ($stable(act_sel) && $stable(act_pre)));

  // R9
  main_trig_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && !main_busy) |=> !main_busy);

  // R9
  pre_trig_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && !pre_busy) |=> !pre_busy);

  // R7
  pre_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_busy) |-> $past(go_pre && gate_en));

  // R8
  main_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_busy) |-> $past(go_main && gate_en));
endmodule

bind trig_frac_clkdiv trig_frac_clkdiv_chk #(
  .NPAR(NPAR), .DIV_W(DIV_W), .PRE_W(PRE_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .go_main(go_main), .go_pre(go_pre),
  .main_busy(main_busy), .pre_busy(pre_busy), .div_pulse(div_pulse),
  .act_div(act_div), .act_pre(act_pre), .act_sel(act_sel)
);

// File: tb/trig_frac_clkdiv_bench.sv
`timescale 1ns/1ps
module trig_frac_clkdiv_bench;
  localparam int NPAR = 4;
  localparam int WIN  = 240;
  // {sel[14:12], pre[11:8], div[7:0]}
  localparam logic [14:0] VEC [0:7] = '{
    {3'd0, 4'd0, 8'd0},
    {3'd0, 4'd1, 8'd16},
    {3'd0, 4'd0, 8'd4},
    {3'd1, 4'd2, 8'd3},
    {3'd2, 4'd0, 8'd10},
    {3'd0, 4'd3, 8'd255},
    {3'd5, 4'd0, 8'd0},
    {3'd3, 4'd0, 8'd0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, gate_en = 1'b1, wr_en = 1'b0, go_main = 1'b0, go_pre = 1'b0;
  logic [NPAR-1:0] par = '0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic main_busy, pre_busy, div_pulse;
  logic [7:0] act_div;
  logic [3:0] act_pre;
  logic [2:0] act_sel;
  int errs = 0, checks = 0, cyc = 0;
  bit done = 1'b0;

  trig_frac_clkdiv u_trig_frac_clkdiv (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .parent_req(par),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .go_main(go_main), .go_pre(go_pre), .main_busy(main_busy), .pre_busy(pre_busy),
    .div_pulse(div_pulse), .act_div(act_div), .act_pre(act_pre), .act_sel(act_sel)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
    par = {1'b0, (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
  endtask

  task automatic stage(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic commit(input bit main);
    if (main) go_main = 1'b1; else go_pre = 1'b1;
    tick();
    go_main = 1'b0; go_pre = 1'b0;
    for (int k = 0; k < 3000 && (main_busy || pre_busy); k++) tick();
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      cnt += int'(div_pulse);
    end
  endtask

  task automatic timed_main(input logic [7:0] nd);
    int k;
    stage(2'd0, nd);
    go_main = 1'b1;
    tick();
    go_main = 1'b0;
    for (k = 0; k < 3000 && act_div != nd; k++) tick();
    check("R8", "pulse on commit cycle", int'(div_pulse), 1);
    check("R8", "busy one cycle after commit", int'(main_busy), 1);
    tick();
    check("R8", "busy second cycle", int'(main_busy), 1);
    tick();
    check("R8", "busy cleared two cycles after commit", int'(main_busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int cnt, exp, k, p, d, rate;
    repeat (3) tick();
    check("R1", "main_busy in reset", int'(main_busy), 0);
    check("R1", "pulse in reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    tick();
    check("R1", "pre_busy", int'(pre_busy), 0);
    check("R1", "act_sel", int'(act_sel), 7);
    check("R1", "act_div", int'(act_div), 0);
    check("R1", "act_pre", int'(act_pre), 0);
    count_pulses(20, cnt);
    check("R5", "no parent at reset", cnt, 0);

    // R6: staged selector is inert until a commit
    stage(2'd2, 8'd0);
    stage(2'd1, 8'd0);
    repeat (5) tick();
    check("R6", "sel unchanged before commit", int'(act_sel), 7);

    // R7: pre-trigger step by step
    go_pre = 1'b1;
    tick();
    go_pre = 1'b0;
    check("R7", "busy after T", int'(pre_busy), 1);
    check("R7", "sel old after T", int'(act_sel), 7);
    tick();
    check("R7", "sel new after T+1", int'(act_sel), 0);
    check("R7", "busy after T+1", int'(pre_busy), 1);
    tick();
    check("R7", "busy after T+2", int'(pre_busy), 1);
    tick();
    check("R7", "busy clear after T+3", int'(pre_busy), 0);

    // R2 R3 R4 R5: table of settings walked in one loop
    for (int i = 0; i < 8; i++) begin
      k = int'(VEC[i][14:12]);
      p = int'(VEC[i][11:8]);
      d = int'(VEC[i][7:0]);
      stage(2'd0, VEC[i][7:0]);
      commit(1'b1);
      stage(2'd1, {4'd0, VEC[i][11:8]});
      stage(2'd2, {5'd0, VEC[i][14:12]});
      commit(1'b0);
      repeat (4) tick();
      count_pulses(WIN, cnt);
      rate = (k < 3) ? k + 1 : 0;
      exp = (rate == 0) ? 0 : (8 * WIN) / (rate * (p + 1) * (d + 8));
      checks++;
      if ((exp == 0 && cnt != 0) || cnt > exp + 1 || cnt < exp - 1) begin
        errs++;
        $display("FAIL R2 R3 R4 R5 vector %0d: actual=%0d expected=%0d", i, cnt, exp);
      end
    end

    // R8: main commit lands on a pulse
    stage(2'd2, 8'd0);
    stage(2'd1, 8'd0);
    commit(1'b0);
    stage(2'd0, 8'd16);
    commit(1'b1);
    timed_main(8'd40);

    // R2: exact integer period, d=16 -> every 3 cycles
    stage(2'd0, 8'd16);
    commit(1'b1);
    for (k = 0; k < 20 && !div_pulse; k++) tick();
    tick();
    cnt = 1;
    while (!div_pulse && cnt < 20) begin tick(); cnt++; end
    check("R2", "integer period", cnt, 3);

    // R6: main trigger does not move selector
    stage(2'd2, 8'd1);
    stage(2'd0, 8'd4);
    commit(1'b1);
    check("R6", "div committed by main", int'(act_div), 4);
    check("R6", "sel untouched by main", int'(act_sel), 0);
    stage(2'd2, 8'd0);
    commit(1'b0);

    // R9: disabled clock
    gate_en = 1'b0;
    stage(2'd2, 8'd2);
    go_pre = 1'b1; go_main = 1'b1;
    tick();
    go_pre = 1'b0; go_main = 1'b0;
    tick();
    check("R9", "pre trigger ignored", int'(pre_busy), 0);
    check("R9", "main trigger ignored", int'(main_busy), 0);
    count_pulses(30, cnt);
    check("R9", "output quiet", cnt, 0);
    gate_en = 1'b1;
    commit(1'b0);
    check("R9", "dropped write leaves sel", int'(act_sel), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule